// File: doc/BRIEF.md
# Shared Delay-Line Converter Hit Arbiter

A group of pixels produces time-over-threshold pulses. All of the pixels feed one delay-line time-to-digital converter. This block decides which pixel owns the converter. The first pixel whose pulse goes high is granted, and the grant lasts until that pixel's pulse has ended and its record has been taken. While the grant is held, new pulses from the other pixels are dropped.

For the granted pulse, the block time-stamps both edges. Each stamp has two parts:
- a coarse value, taken from a free-running clock counter;
- a fine value, taken by encoding the 32-tap delay-line snapshot into 5 bits.

The difference between the two stamps gives the pulse width, which downstream logic uses to correct time walk. The snapshot enters as a tap vector and is assumed to be settled for each clock. The pulse inputs are synchronous samples.

One record is emitted for each granted pulse. It carries the pixel index and the two coarse/fine pairs. A valid/ready pair qualifies the record, and the record is held until it is accepted.

Top module: `tdc_hit_arbiter`

## Requirements
- R1: While reset is asserted and after its release, `busy` and `rec_valid` are 0. The coarse counter restarts at 0 on reset: a coarse value captured at the N-th rising clock edge after release reads N-1.
- R2: The coarse counter advances by exactly one per clock. The difference between the falling and rising coarse values of a record equals the number of clock edges at which the granted pulse was sampled high.
- R3: When idle, a pixel whose `tot_in` bit is 0 at one clock edge and 1 at the next is granted at that second edge. `busy` reads 1 after that edge.
- R4: If several pixels rise at the same edge, the pixel with the lowest index is granted.
- R5: A rising pulse on any pixel while `busy` is 1 is never serviced. A pixel that is still high when the block returns to idle is not granted until it falls and rises again.
- R6: Only the fall of the granted pixel ends the capture. Falls of other pixels have no effect on `rec_valid` or `busy`.
- R7: Each fine code is the highest index i in 1..31 for which tap i and tap i-1 are both 1, or 0 if there is no such i. An isolated 1 above the thermometer edge is therefore ignored. Tap 0 is the least significant bit of `taps`.
- R8: The record fields are:
  - `rec_pixel`: 3-bit index;
  - `rec_rise_coarse` and `rec_fall_coarse`: 32 bits each;
  - `rec_rise_fine` and `rec_fall_fine`: 5 bits each.
- R9: Record handshake:
  - `rec_valid` rises one edge after the granted pixel's fall is captured.
  - `rec_valid` and all record fields hold steady while `rec_ready` is 0.
  - On an edge with `rec_valid` and `rec_ready` both 1, `busy` and `rec_valid` drop.
- R10: The rising stamp uses the counter value and tap snapshot present at the edge where the rise is detected. The falling stamp uses those present at the edge where the fall is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tot_in | input | 5 | Sampled time-over-threshold pulse, one bit per pixel |
| taps | input | 32 | Delay-line tap snapshot, tap 0 in bit 0 |
| rec_ready | input | 1 | Consumer accepts the record |
| busy | output | 1 | Converter is owned by a pixel |
| rec_valid | output | 1 | Record is available |
| rec_pixel | output | 3 | Index of the granted pixel |
| rec_rise_coarse | output | 32 | Counter value at the rising edge |
| rec_rise_fine | output | 5 | Encoded snapshot at the rising edge |
| rec_fall_coarse | output | 32 | Counter value at the falling edge |
| rec_fall_fine | output | 5 | Encoded snapshot at the falling edge |

## Verification
The bench covers several arbitration cases:
- **Simultaneous rises.** A design without index priority would report a higher pixel.
- **A second pixel rising mid-pulse.** A design that queued hits would emit an extra record or report the wrong pixel.
- **A non-granted pixel falling first.** A design watching any fall would close the record early.
- **A latecomer still high when the grant is released.** A design that re-armed on level rather than edge would start a spurious capture.

On the encoder side, it drives bubbled, single-bit, empty and full snapshots. A plain priority encoder would report the bubble position in these cases.

On the handshake side, it holds off `rec_ready` and checks the fields stay frozen, and it uses one-cycle pulses to catch off-by-one coarse stamps.

// File: rtl/tdc_hit_arbiter.sv
module tdc_hit_arbiter #(
  parameter int NPIX = 5,
  parameter int NTAP = 32,
  parameter int CW   = 32,
  localparam int PW  = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int FW  = $clog2(NTAP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIX-1:0] tot_in,
  input  logic [NTAP-1:0] taps,
  input  logic            rec_ready,
  output logic            busy,
  output logic            rec_valid,
  output logic [PW-1:0]   rec_pixel,
  output logic [CW-1:0]   rec_rise_coarse,
  output logic [FW-1:0]   rec_rise_fine,
  output logic [CW-1:0]   rec_fall_coarse,
  output logic [FW-1:0]   rec_fall_fine
);

  typedef enum logic [1:0] {S_IDLE, S_HIGH, S_DONE} st_t;

  st_t             st;
  logic [CW-1:0]   coarse;
  logic [NPIX-1:0] tot_q;
  logic [NPIX-1:0] rises;
  logic [PW-1:0]   winner;
  logic [FW-1:0]   fine_now;

  function automatic logic [FW-1:0] therm_code(input logic [NTAP-1:0] t);
    logic [FW-1:0] r;
    r = '0;
    for (int i = 1; i < NTAP; i++)
      if (t[i] && t[i-1]) r = FW'(i);
    return r;
  endfunction

  assign rises    = tot_in & ~tot_q;
  assign fine_now = therm_code(taps);
  assign busy     = (st != S_IDLE);
  assign rec_valid = (st == S_DONE);

  always_comb begin
    winner = '0;
    for (int p = NPIX - 1; p >= 0; p--)
      if (rises[p]) winner = PW'(p);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse <= '0;
      tot_q  <= '0;
    end else begin
      coarse <= coarse + 1'b1;
      tot_q  <= tot_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= S_IDLE;
      rec_pixel       <= '0;
      rec_rise_coarse <= '0;
      rec_rise_fine   <= '0;
      rec_fall_coarse <= '0;
      rec_fall_fine   <= '0;
    end else begin
      case (st)
        S_IDLE: if (|rises) begin
          st              <= S_HIGH;
          rec_pixel       <= winner;
          rec_rise_coarse <= coarse;
          rec_rise_fine   <= fine_now;
        end
        S_HIGH: if (!tot_in[rec_pixel]) begin
          st              <= S_DONE;
          rec_fall_coarse <= coarse;
          rec_fall_fine   <= fine_now;
        end
        S_DONE: if (rec_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tdc_hit_arbiter_chk.sv
module tdc_hit_arbiter_chk #(
  parameter int NPIX = 5,
  parameter int CW   = 32,
  parameter int PW   = 3,
  parameter int FW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_ready,
  input logic          busy,
  input logic          rec_valid,
  input logic [PW-1:0] rec_pixel,
  input logic [CW-1:0] rec_rise_coarse,
  input logic [FW-1:0] rec_rise_fine,
  input logic [CW-1:0] rec_fall_coarse,
  input logic [FW-1:0] rec_fall_fine
);

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_pixel) && $stable(rec_rise_coarse)
      && $stable(rec_fall_coarse) && $stable(rec_rise_fine) && $stable(rec_fall_fine)); // R9

  AST_VALID_WHILE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> busy); // R9

  AST_RELEASE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_ready |=> !busy && !rec_valid); // R9

  AST_PIXEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_pixel < PW'(NPIX)); // R3

  AST_WIDTH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_fall_coarse - rec_rise_coarse) != '0); // R2

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rec_valid |=> busy); // R5

endmodule

bind tdc_hit_arbiter tdc_hit_arbiter_chk #(.NPIX(NPIX), .CW(CW), .PW(PW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_ready(rec_ready), .busy(busy), .rec_valid(rec_valid),
  .rec_pixel(rec_pixel), .rec_rise_coarse(rec_rise_coarse), .rec_rise_fine(rec_rise_fine),
  .rec_fall_coarse(rec_fall_coarse), .rec_fall_fine(rec_fall_fine));

// File: tb/tdc_hit_arbiter_tb.sv
module tdc_hit_arbiter_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  tot_in = '0;
  logic [31:0] taps = '0;
  logic        rec_ready = 1;
  logic        busy, rec_valid;
  logic [2:0]  rec_pixel;
  logic [31:0] rec_rise_coarse, rec_fall_coarse;
  logic [4:0]  rec_rise_fine, rec_fall_fine;

  int checks = 0;
  int failures = 0;
  logic [31:0] cyc;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0; else cyc <= cyc + 1;

  tdc_hit_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .tot_in(tot_in), .taps(taps), .rec_ready(rec_ready),
    .busy(busy), .rec_valid(rec_valid), .rec_pixel(rec_pixel),
    .rec_rise_coarse(rec_rise_coarse), .rec_rise_fine(rec_rise_fine),
    .rec_fall_coarse(rec_fall_coarse), .rec_fall_fine(rec_fall_fine));

  typedef struct packed {
    logic [4:0]  mask;
    logic [31:0] tr;
    logic [7:0]  len;
    logic [31:0] tf;
    logic [2:0]  pix;
    logic [4:0]  fr;
    logic [4:0]  ff;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{5'b00001, 32'h0000_000F, 8'd3, 32'h0000_FFFF, 3'd0, 5'd3,  5'd15},
    '{5'b10000, 32'hFFFF_FFFF, 8'd1, 32'h0000_0000, 3'd4, 5'd31, 5'd0},
    '{5'b01010, 32'h0010_00FF, 8'd5, 32'h0000_0001, 3'd1, 5'd7,  5'd0},
    '{5'b11100, 32'h7FFF_FFFF, 8'd2, 32'h0000_0003, 3'd2, 5'd30, 5'd1},
    '{5'b00100, 32'h0005_0003, 8'd4, 32'h3FFF_FFFF, 3'd2, 5'd1,  5'd29},
    '{5'b11000, 32'h0000_0002, 8'd2, 32'hFFFF_0000, 3'd3, 5'd0,  5'd31}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_rec(input string req, input logic [2:0] pix, input logic [31:0] cr,
                         input logic [4:0] fr, input logic [31:0] cf, input logic [4:0] ff);
    chk(rec_valid === 1'b1, req, "rec_valid", {63'b0, rec_valid}, 64'd1);
    chk(rec_pixel === pix, req, "pixel", {61'b0, rec_pixel}, {61'b0, pix});
    chk(rec_rise_coarse === cr, "R10", "rise coarse", {32'b0, rec_rise_coarse}, {32'b0, cr});
    chk(rec_fall_coarse === cf, "R2", "fall coarse", {32'b0, rec_fall_coarse}, {32'b0, cf});
    chk(rec_rise_fine === fr, "R7", "rise fine", {59'b0, rec_rise_fine}, {59'b0, fr});
    chk(rec_fall_fine === ff, "R7", "fall fine", {59'b0, rec_fall_fine}, {59'b0, ff});
  endtask

  task automatic run_all();
    logic [31:0] cr, cf;
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && rec_valid === 1'b0, "R1", "in reset", {62'b0, busy, rec_valid}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && rec_valid === 1'b0, "R1", "after release", {62'b0, busy, rec_valid}, 64'd0);

    // table walk: R3 R4 R7 R8 R9 R10
    for (int v = 0; v < 6; v++) begin
      tot_in = VEC[v].mask; taps = VEC[v].tr; cr = cyc;
      for (int k = 1; k <= int'(VEC[v].len); k++) begin
        @(negedge clk);
        if (k == 1) chk(busy === 1'b1, "R3", "busy after rise", {63'b0, busy}, 64'd1);
      end
      tot_in = '0; taps = VEC[v].tf; cf = cyc;
      @(negedge clk);
      chk_rec("R4", VEC[v].pix, cr, VEC[v].fr, cf, VEC[v].ff);
      @(negedge clk);
      chk(busy === 1'b0 && rec_valid === 1'b0, "R9", "release after accept",
          {62'b0, busy, rec_valid}, 64'd0);
    end

    // R5: latecomer ignored, not re-armed on level
    tot_in = 5'b00100; taps = 32'h0000_003F; cr = cyc;
    @(negedge clk); tot_in = 5'b00101;
    @(negedge clk);
    @(negedge clk); tot_in = 5'b00001; cf = cyc;
    @(negedge clk);
    chk_rec("R5", 3'd2, cr, 5'd5, cf, 5'd5);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(busy === 1'b0, "R5", "held latecomer not granted", {63'b0, busy}, 64'd0);
    end
    tot_in = '0; @(negedge clk);
    tot_in = 5'b00001; cr = cyc;
    @(negedge clk);
    chk(busy === 1'b1, "R3", "fresh rise granted", {63'b0, busy}, 64'd1);
    tot_in = '0; cf = cyc;
    @(negedge clk);
    chk_rec("R5", 3'd0, cr, 5'd5, cf, 5'd5);
    @(negedge clk);

    // R6 other pixel falls; R9 backpressure
    rec_ready = 0; taps = 32'h0000_0007;
    tot_in = 5'b01010; cr = cyc;
    @(negedge clk); tot_in = 5'b00010;
    @(negedge clk);
    chk(rec_valid === 1'b0 && busy === 1'b1, "R6", "other fall ignored",
        {62'b0, busy, rec_valid}, 64'd2);
    tot_in = '0; cf = cyc;
    @(negedge clk);
    chk_rec("R6", 3'd1, cr, 5'd2, cf, 5'd2);
    for (int k = 0; k < 4; k++) begin
      taps = 32'hFFFF_FFFF; tot_in = 5'b10000;
      @(negedge clk);
      tot_in = '0;
      chk_rec("R9", 3'd1, cr, 5'd2, cf, 5'd2);
    end
    rec_ready = 1;
    @(negedge clk);
    chk(busy === 1'b0, "R9", "release after late ready", {63'b0, busy}, 64'd0);

    // R1 reset mid-capture
    tot_in = 5'b00001;
    @(negedge clk);
    chk(busy === 1'b1, "R3", "busy before reset", {63'b0, busy}, 64'd1);
    rst_n = 0;
    @(negedge clk);
    chk(busy === 1'b0 && rec_valid === 1'b0, "R1", "reset clears grant",
        {62'b0, busy, rec_valid}, 64'd0);
    tot_in = '0; rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        #400_000;
        failures++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule